// File: doc/BRIEF.md
# Branch-Aware Combinational ALU

This block is the arithmetic core of a 32-bit load/store processor datapath. It has no clock and no state. It takes two operands, a 5-bit operation selector and a 5-bit immediate shift count. It returns three things in the same evaluation: a main result, a high word, and a one-bit condition for the branch unit. The surrounding core selects the operands, extends immediates and holds the high/low register pair. The ALU only computes.

The operations are add, subtract, the three bitwise logic functions, and six shifts. Three of the shifts take their count from the immediate count input. The other three take it from the low bits of operand A and shift operand B. The block also does signed and unsigned set-less-than, and signed and unsigned multiply and divide. Multiply and divide use both output words. A pass-through code hands operand A to the high/low move path. Six comparison codes drive only the condition output. Loading an upper immediate needs no code of its own: the core issues the immediate-count left shift with a count of 16 on operand B.

Every input pattern resolves to a defined value. This covers division by zero, the one signed-division overflow case, and selector codes that are not assigned.

Top module: `cmp_alu`

## Requirements
- R1: Code 0 returns A+B and code 1 returns A-B, both wrapping modulo 2^32 with no overflow indication.
- R2: Code 4 returns A AND B, code 5 returns A OR B, and code 6 returns A XOR B.
- R3: Codes 7 (left logical), 9 (right logical) and 11 (right arithmetic) shift B by the shift-count input. Code 7 with a count of 16 places B[15:0] in bits 31:16 and zeros below, which is the upper-immediate load.
- R4: Codes 8 (left logical), 10 (right logical) and 12 (right arithmetic) shift B by A[4:0]. A[31:5] and the shift-count input have no effect on these codes.
- R5: Code 20 (signed) and code 21 (unsigned) return 32'd1 when A < B and 32'd0 otherwise.
- R6: The comparison codes set the condition output as follows: 13 when A == B, 14 when signed A < 0, 15 when signed A <= 0, 16 when signed A > 0, 17 when signed A >= 0, and 18 when A != B. On these codes the result and the high word are zero.
- R7: The condition output is 0 for every code outside 13..18.
- R8: Code 2 (signed) and code 22 (unsigned) form the 64-bit product. The upper 32 bits go on the high word and the lower 32 bits on the result.
- R9: Code 3 (signed) and code 23 (unsigned) put the quotient on the result and the remainder on the high word. The signed quotient truncates toward zero and the signed remainder takes the sign of the dividend. Signed 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R10: A divisor of zero on code 3 or code 23 gives quotient 0xFFFFFFFF and remainder equal to A. No error is raised.
- R11: Code 19 returns A on the result and zero on the high word.
- R12: Codes 24 to 31 return zero on the result, zero on the high word and 0 on the condition.
- R13: The high word is zero for every code except 2, 3, 22 and 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; dividend, comparison subject, variable shift count source |
| opnd_b | input | 32 | Second operand; shifted value, divisor |
| op_sel | input | 5 | Operation selector |
| shamt | input | 5 | Immediate shift count for codes 7, 9, 11 |
| res_lo | output | 32 | Main result; product low word or quotient |
| res_hi | output | 32 | Product high word or remainder; zero otherwise |
| cond | output | 1 | Branch condition from comparison codes |

## Verification
A table of operand pairs exercises every code with values chosen to expose confusions. Sign-bit operands tell arithmetic from logical right shifts and signed from unsigned set-less-than and multiply. Mixed-sign dividends and divisors pin down truncation direction and remainder sign. Zero and ±1 around the comparison boundary separate strict from non-strict tests. Junk in A[31:5] and in the unused count input shows which count source each shift uses. A sweep of all 32 selector codes with identical operands confirms that only the six comparison codes raise the condition and only the four multiply/divide codes drive the high word.

// File: rtl/cmp_alu_pkg.sv
package cmp_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'd0,
    OP_SUB    = 5'd1,
    OP_MUL    = 5'd2,
    OP_DIV    = 5'd3,
    OP_AND    = 5'd4,
    OP_OR     = 5'd5,
    OP_XOR    = 5'd6,
    OP_SHL_I  = 5'd7,
    OP_SHL_V  = 5'd8,
    OP_SHR_I  = 5'd9,
    OP_SHR_V  = 5'd10,
    OP_ASR_I  = 5'd11,
    OP_ASR_V  = 5'd12,
    OP_CEQ    = 5'd13,
    OP_CLTZ   = 5'd14,
    OP_CLEZ   = 5'd15,
    OP_CGTZ   = 5'd16,
    OP_CGEZ   = 5'd17,
    OP_CNE    = 5'd18,
    OP_PASS   = 5'd19,
    OP_SLT    = 5'd20,
    OP_SLTU   = 5'd21,
    OP_MULU   = 5'd22,
    OP_DIVU   = 5'd23
  } alu_op_e;

  function automatic logic is_compare(input logic [OP_W-1:0] op);
    return (op >= OP_CEQ) && (op <= OP_CNE);
  endfunction

  function automatic logic is_muldiv(input logic [OP_W-1:0] op);
    return (op == OP_MUL) || (op == OP_DIV) || (op == OP_MULU) || (op == OP_DIVU);
  endfunction

endpackage

// File: rtl/cmp_alu_shifter.sv
module cmp_alu_shifter
  import cmp_alu_pkg::*;
#(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [OP_W-1:0] op,
  input  logic [SHW-1:0]  imm_cnt,
  input  logic [W-1:0]    cnt_src,
  input  logic [W-1:0]    value,
  output logic [W-1:0]    shifted
);

  logic [SHW-1:0] amount;
  logic           var_form;

  // Variable forms take the count from the low bits of the count source.
  always_comb begin
    var_form = (op == OP_SHL_V) || (op == OP_SHR_V) || (op == OP_ASR_V);
    amount   = var_form ? cnt_src[SHW-1:0] : imm_cnt;
  end

  always_comb begin
    unique case (op)
      OP_SHL_I, OP_SHL_V: shifted = value << amount;
      OP_SHR_I, OP_SHR_V: shifted = value >> amount;
      OP_ASR_I, OP_ASR_V: shifted = W'($signed(value) >>> amount);
      default:            shifted = '0;
    endcase
  end

endmodule

// File: rtl/cmp_alu_muldiv.sv
module cmp_alu_muldiv
  import cmp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    lo,
  output logic [W-1:0]    hi
);

  logic           sgn;
  logic           neg_a;
  logic           neg_b;
  logic [2*W-1:0] ext_a;
  logic [2*W-1:0] ext_b;
  logic [2*W-1:0] product;
  logic [W-1:0]   mag_a;
  logic [W-1:0]   mag_b;
  logic [W-1:0]   uq;
  logic [W-1:0]   ur;
  logic [W-1:0]   quot;
  logic [W-1:0]   rem;

  always_comb begin
    sgn   = (op == OP_MUL) || (op == OP_DIV);
    neg_a = sgn & a[W-1];
    neg_b = sgn & b[W-1];
  end

  // One multiplier: extending operands to 2W bits makes the low 2W bits
  // of the product right for both signed and unsigned forms.
  always_comb begin
    ext_a   = {{W{neg_a}}, a};
    ext_b   = {{W{neg_b}}, b};
    product = ext_a * ext_b;
  end

  // One unsigned divider on magnitudes; signs are reapplied afterwards.
  always_comb begin
    mag_a = neg_a ? (~a + W'(1)) : a;
    mag_b = neg_b ? (~b + W'(1)) : b;
    uq    = (mag_b == '0) ? '0 : (mag_a / mag_b);
    ur    = (mag_b == '0) ? '0 : (mag_a % mag_b);
  end

  always_comb begin
    if (b == '0) begin
      quot = '1;
      rem  = a;
    end else begin
      quot = (neg_a ^ neg_b) ? (~uq + W'(1)) : uq;
      rem  = neg_a ? (~ur + W'(1)) : ur;
    end
  end

  always_comb begin
    unique case (op)
      OP_MUL, OP_MULU: begin
        lo = product[W-1:0];
        hi = product[2*W-1:W];
      end
      OP_DIV, OP_DIVU: begin
        lo = quot;
        hi = rem;
      end
      default: begin
        lo = '0;
        hi = '0;
      end
    endcase
  end

endmodule

// File: rtl/cmp_alu_cmp.sv
module cmp_alu_cmp
  import cmp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic            flag
);

  logic a_neg;
  logic a_zero;
  logic same;

  always_comb begin
    a_neg  = a[W-1];
    a_zero = (a == '0);
    same   = (a == b);
  end

  always_comb begin
    unique case (op)
      OP_CEQ:  flag = same;
      OP_CNE:  flag = !same;
      OP_CLTZ: flag = a_neg;
      OP_CLEZ: flag = a_neg | a_zero;
      OP_CGTZ: flag = !a_neg & !a_zero;
      OP_CGEZ: flag = !a_neg;
      default: flag = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmp_alu.sv
module cmp_alu
  import cmp_alu_pkg::*;
#(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [OP_W-1:0] op_sel,
  input  logic [SHW-1:0]  shamt,
  output logic [W-1:0]    res_lo,
  output logic [W-1:0]    res_hi,
  output logic            cond
);

  logic [W-1:0] sh_out;
  logic [W-1:0] md_lo;
  logic [W-1:0] md_hi;
  logic         cmp_flag;
  logic         lt_s;
  logic         lt_u;

  cmp_alu_shifter #(.W(W)) u_shift (
    .op      (op_sel),
    .imm_cnt (shamt),
    .cnt_src (opnd_a),
    .value   (opnd_b),
    .shifted (sh_out)
  );

  cmp_alu_muldiv #(.W(W)) u_muldiv (
    .op (op_sel),
    .a  (opnd_a),
    .b  (opnd_b),
    .lo (md_lo),
    .hi (md_hi)
  );

  cmp_alu_cmp #(.W(W)) u_cmp (
    .op   (op_sel),
    .a    (opnd_a),
    .b    (opnd_b),
    .flag (cmp_flag)
  );

  always_comb begin
    lt_s = $signed(opnd_a) < $signed(opnd_b);
    lt_u = opnd_a < opnd_b;
  end

  always_comb begin
    res_lo = '0;
    res_hi = '0;
    unique case (op_sel)
      OP_ADD:  res_lo = opnd_a + opnd_b;
      OP_SUB:  res_lo = opnd_a - opnd_b;
      OP_AND:  res_lo = opnd_a & opnd_b;
      OP_OR:   res_lo = opnd_a | opnd_b;
      OP_XOR:  res_lo = opnd_a ^ opnd_b;
      OP_SHL_I, OP_SHL_V, OP_SHR_I, OP_SHR_V, OP_ASR_I, OP_ASR_V:
               res_lo = sh_out;
      OP_SLT:  res_lo = W'(lt_s);
      OP_SLTU: res_lo = W'(lt_u);
      OP_PASS: res_lo = opnd_a;
      OP_MUL, OP_MULU, OP_DIV, OP_DIVU: begin
               res_lo = md_lo;
               res_hi = md_hi;
      end
      default: begin
               res_lo = '0;
               res_hi = '0;
      end
    endcase
  end

  assign cond = cmp_flag;

endmodule

// File: rtl/cmp_alu_chk.sv
module cmp_alu_chk
  import cmp_alu_pkg::*;
#(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input logic [W-1:0]    opnd_a,
  input logic [W-1:0]    opnd_b,
  input logic [OP_W-1:0] op_sel,
  input logic [SHW-1:0]  shamt,
  input logic [W-1:0]    res_lo,
  input logic [W-1:0]    res_hi,
  input logic            cond
);

  always_comb begin
    if (!is_compare(op_sel)) begin
      a_r7_flag_only_compare: assert (cond == 1'b0);
    end
    if (!is_muldiv(op_sel)) begin
      a_r13_hi_idle: assert (res_hi == '0);
    end
    if (op_sel >= 5'd24) begin
      a_r12_unused_zero: assert (res_lo == '0 && res_hi == '0 && cond == 1'b0);
    end
    if (op_sel == OP_SLT || op_sel == OP_SLTU) begin
      a_r5_slt_binary: assert (res_lo[W-1:1] == '0);
    end
    if ((op_sel == OP_DIV || op_sel == OP_DIVU) && opnd_b == '0) begin
      a_r10_div_zero: assert (res_lo == '1 && res_hi == opnd_a);
    end
    if (op_sel == OP_PASS) begin
      a_r11_pass_a: assert (res_lo == opnd_a);
    end
    if (is_compare(op_sel)) begin
      a_r6_cmp_quiet: assert (res_lo == '0 && res_hi == '0);
    end
    if (op_sel == OP_SHL_I && shamt == SHW'(16)) begin
      a_r3_upper_load: assert (res_lo == {opnd_b[15:0], 16'h0000});
    end
  end

endmodule

bind cmp_alu cmp_alu_chk #(.W(W)) u_chk (
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .op_sel (op_sel),
  .shamt  (shamt),
  .res_lo (res_lo),
  .res_hi (res_hi),
  .cond   (cond)
);

// File: tb/cmp_alu_test.sv
module cmp_alu_test;

  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  op;
    logic [4:0]  sh;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        c;
  } vec_t;

  localparam int NV = 38;
  // req, op, shamt, A, B, expected lo, expected hi, expected cond
  localparam vec_t VECS [NV] = '{
    // R1 add/sub wrap
    '{4'd1, 5'd0,  5'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 1'b0},
    '{4'd1, 5'd0,  5'd0,  32'hFFFFFFFF, 32'h00000002, 32'h00000001, 32'h0, 1'b0},
    '{4'd1, 5'd1,  5'd0,  32'h00000005, 32'h00000007, 32'hFFFFFFFE, 32'h0, 1'b0},
    // R2 logic
    '{4'd2, 5'd4,  5'd0,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 32'h0, 1'b0},
    '{4'd2, 5'd5,  5'd0,  32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 32'h0, 1'b0},
    '{4'd2, 5'd6,  5'd0,  32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 32'h0, 1'b0},
    // R3 immediate-count shifts, A holds junk
    '{4'd3, 5'd7,  5'd4,  32'h0000001F, 32'h80000001, 32'h00000010, 32'h0, 1'b0},
    '{4'd3, 5'd7,  5'd16, 32'h00000000, 32'h1234ABCD, 32'hABCD0000, 32'h0, 1'b0},
    '{4'd3, 5'd9,  5'd4,  32'h00000001, 32'h80000000, 32'h08000000, 32'h0, 1'b0},
    '{4'd3, 5'd11, 5'd4,  32'h00000001, 32'h80000000, 32'hF8000000, 32'h0, 1'b0},
    // R4 variable shifts, junk in A[31:5] and shamt
    '{4'd4, 5'd8,  5'd31, 32'hFFFFFFE3, 32'h00000001, 32'h00000008, 32'h0, 1'b0},
    '{4'd4, 5'd10, 5'd1,  32'h00000024, 32'hF0000000, 32'h0F000000, 32'h0, 1'b0},
    '{4'd4, 5'd12, 5'd0,  32'h0000001F, 32'h80000000, 32'hFFFFFFFF, 32'h0, 1'b0},
    // R5 set-less-than
    '{4'd5, 5'd20, 5'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000001, 32'h0, 1'b0},
    '{4'd5, 5'd21, 5'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h0, 1'b0},
    '{4'd5, 5'd20, 5'd0,  32'h00000005, 32'h00000005, 32'h00000000, 32'h0, 1'b0},
    // R6 comparisons
    '{4'd6, 5'd13, 5'd0,  32'h00001234, 32'h00001234, 32'h0, 32'h0, 1'b1},
    '{4'd6, 5'd13, 5'd0,  32'h00000001, 32'h00000002, 32'h0, 32'h0, 1'b0},
    '{4'd6, 5'd18, 5'd0,  32'h00000001, 32'h00000002, 32'h0, 32'h0, 1'b1},
    '{4'd6, 5'd14, 5'd0,  32'h80000000, 32'h00000000, 32'h0, 32'h0, 1'b1},
    '{4'd6, 5'd14, 5'd0,  32'h00000000, 32'h00000000, 32'h0, 32'h0, 1'b0},
    '{4'd6, 5'd15, 5'd0,  32'h00000000, 32'h00000000, 32'h0, 32'h0, 1'b1},
    '{4'd6, 5'd16, 5'd0,  32'h00000000, 32'h00000000, 32'h0, 32'h0, 1'b0},
    '{4'd6, 5'd16, 5'd0,  32'h00000001, 32'h00000000, 32'h0, 32'h0, 1'b1},
    '{4'd6, 5'd17, 5'd0,  32'h00000000, 32'h00000000, 32'h0, 32'h0, 1'b1},
    '{4'd6, 5'd17, 5'd0,  32'hFFFFFFFF, 32'h00000000, 32'h0, 32'h0, 1'b0},
    // R8 multiply
    '{4'd8, 5'd2,  5'd0,  32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0},
    '{4'd8, 5'd22, 5'd0,  32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFE, 32'h00000001, 1'b0},
    '{4'd8, 5'd2,  5'd0,  32'h00010000, 32'h00010000, 32'h00000000, 32'h00000001, 1'b0},
    // R9 divide
    '{4'd9, 5'd3,  5'd0,  32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFD, 32'hFFFFFFFF, 1'b0},
    '{4'd9, 5'd3,  5'd0,  32'h00000007, 32'hFFFFFFFE, 32'hFFFFFFFD, 32'h00000001, 1'b0},
    '{4'd9, 5'd23, 5'd0,  32'hFFFFFFF9, 32'h00000002, 32'h7FFFFFFC, 32'h00000001, 1'b0},
    '{4'd9, 5'd3,  5'd0,  32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h00000000, 1'b0},
    // R10 divide by zero
    '{4'd10, 5'd3,  5'd0, 32'h00001234, 32'h00000000, 32'hFFFFFFFF, 32'h00001234, 1'b0},
    '{4'd10, 5'd23, 5'd0, 32'h0000DEAD, 32'h00000000, 32'hFFFFFFFF, 32'h0000DEAD, 1'b0},
    // R11 pass-through
    '{4'd11, 5'd19, 5'd0, 32'hCAFEF00D, 32'h12345678, 32'hCAFEF00D, 32'h0, 1'b0},
    // R12 unused codes
    '{4'd12, 5'd24, 5'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 1'b0},
    '{4'd12, 5'd31, 5'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 1'b0}
  };

  logic        clk;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [4:0]  op_sel;
  logic [4:0]  shamt;
  logic [31:0] res_lo;
  logic [31:0] res_hi;
  logic        cond;

  int n_run;
  int n_fail;
  bit done;

  cmp_alu uut (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .op_sel (op_sel),
    .shamt  (shamt),
    .res_lo (res_lo),
    .res_hi (res_hi),
    .cond   (cond)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [4:0] sh,
                       input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    op_sel = op;
    shamt  = sh;
    opnd_a = a;
    opnd_b = b;
    @(negedge clk);
  endtask

  initial begin
    n_run  = 0;
    n_fail = 0;
    done   = 1'b0;
    opnd_a = '0;
    opnd_b = '0;
    op_sel = '0;
    shamt  = '0;

    // Idle state: all-zero inputs select add of zeros (R1, R7, R13)
    @(negedge clk);
    check("R1", "idle lo", res_lo, 32'h0);
    check("R13", "idle hi", res_hi, 32'h0);
    check("R7", "idle cond", {31'h0, cond}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      apply(VECS[i].op, VECS[i].sh, VECS[i].a, VECS[i].b);
      tag = $sformatf("R%0d op%0d", VECS[i].req, VECS[i].op);
      check(tag, "lo", res_lo, VECS[i].lo);
      check(tag, "hi", res_hi, VECS[i].hi);
      check(tag, "cond", {31'h0, cond}, {31'h0, VECS[i].c});
    end

    // Sweep of every code with A == B == 1: only 13, 16, 17 raise cond
    // (R6, R7); hi stays zero outside 2, 3, 22, 23 (R13); 24..31 zero (R12).
    for (int k = 0; k < 32; k++) begin
      logic exp_c;
      apply(5'(k), 5'd0, 32'h1, 32'h1);
      exp_c = (k == 13) || (k == 16) || (k == 17);
      check("R7", $sformatf("sweep cond op%0d", k), {31'h0, cond}, {31'h0, exp_c});
      if (!(k == 2 || k == 3 || k == 22 || k == 23))
        check("R13", $sformatf("sweep hi op%0d", k), res_hi, 32'h0);
      if (k >= 24)
        check("R12", $sformatf("sweep lo op%0d", k), res_lo, 32'h0);
    end

    // Corner: full-width shift count of 31 on both forms (R3, R4)
    apply(5'd11, 5'd31, 32'h0, 32'h40000000);
    check("R3", "asr by 31 positive", res_lo, 32'h0);
    apply(5'd8, 5'd0, 32'h0000003F, 32'h00000003);
    check("R4", "shl var by 31", res_lo, 32'h80000000);

    // Corner: largest unsigned product (R8)
    apply(5'd22, 5'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R8", "mulu max lo", res_lo, 32'h00000001);
    check("R8", "mulu max hi", res_hi, 32'hFFFFFFFE);

    // Corner: signed divide of negative by zero keeps dividend (R10)
    apply(5'd3, 5'd0, 32'h80000000, 32'h0);
    check("R10", "div0 neg quot", res_lo, 32'hFFFFFFFF);
    check("R10", "div0 neg rem", res_hi, 32'h80000000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule